// File: doc/BRIEF.md
# Q23 First-Order Recursive Lowpass

This block is a single-channel first-order recursive lowpass filter working on signed 24-bit fixed-point values with one sign bit and 23 fraction bits. Each accepted sample x produces one result y = a1·y_prev + b0·x. The feedback product is formed first, onto a cleared accumulator. The input product is added to it next. The sum then passes through a saturating slice, which drives both an output holding register and the stored previous output.

Samples arrive through a valid/ready pair, and each accepted sample is read once. The filter then stays idle until the next sample is offered. The two coefficients live in a tiny writable bank that may be rewritten at any time. A copy taken when a sample is accepted isolates a running computation from those writes. A synchronous clear input drops the filter memory to zero without touching the coefficients.

Top module: `iir_q23_lowpass`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, out_data is 0 and the stored previous output is 0, so the first result equals floor(b0·x / 2^23).
- R2: Coefficient word address 0 (coef_sel = 0) holds the feedback coefficient a1 and address 1 holds the input coefficient b0. Reset loads a1 = 0x733333 and b0 = 0x0CCCCC. A write with coef_we = 1 replaces the selected word on the clock edge.
- R3: in_ready is 1 only while the filter is idle, and a sample is taken only on an edge where in_valid and in_ready are both 1. A value offered while in_ready is 0 produces no result and leaves the filter state unchanged.
- R4: out_valid is a single-cycle pulse that rises on the third rising edge after the accepting edge. in_ready returns to 1 on that same edge.
- R5: Each result is the 49-bit two's-complement sum y_prev·a1 + x·b0 shifted right arithmetically by 23 bits, which truncates toward minus infinity.
- R6: A shifted sum above 0x7FFFFF yields 0x7FFFFF, and one below -0x800000 yields 0x800000.
- R7: The value fed back as y_prev for the next sample is the saturated result, identical to the value shown on out_data.
- R8: A cycle with clr = 1 sets the stored previous output to zero. Reset does the same.
- R9: A coefficient write made while a sample is being computed does not change that sample's result. It applies from the next accepted sample on.
- R10: With the reset coefficients and a constant input of 0x400000, the output settles within 64 LSB of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero the stored previous output |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | Filter is idle and will take a sample |
| in_data | input | 24 | Input sample, signed Q1.23 |
| coef_we | input | 1 | Coefficient write enable |
| coef_sel | input | 1 | Coefficient word select: 0 feedback, 1 input |
| coef_wdata | input | 24 | Coefficient write value, signed Q1.23 |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 24 | Output holding register, signed Q1.23 |

## Verification
The hardest case to create from the ports is a saturated value being fed back. The clamp has to be reached first, and only the sample after it shows whether the stored state was clamped. The stimulus sets both coefficients near +1 and drives full-scale inputs of each sign until the output pins at a rail. It then switches to a half-gain feedback coefficient with zero input gain, so the next result reveals the stored value exactly. The other case is a coefficient write landing during a running computation. The bench makes that write on the cycle after acceptance and compares both that result and the following one against a model that changes its coefficients only between samples.

// File: rtl/iir_pkg.sv
package iir_pkg;

    localparam int DW   = 24;          // sample and coefficient width
    localparam int FRAC = DW - 1;      // fraction bits
    localparam int AW   = 2 * DW + 1;  // accumulator width (sum of two products)

    typedef logic signed [DW-1:0] sample_t;
    typedef logic signed [AW-1:0] acc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FB,
        ST_IN,
        ST_SAT
    } phase_e;

    typedef struct packed {
        sample_t a1;
        sample_t b0;
    } coef_t;

    localparam sample_t SAT_HI = {1'b0, {(DW-1){1'b1}}};
    localparam sample_t SAT_LO = {1'b1, {(DW-1){1'b0}}};

    // Take accumulator bits [2*DW-2 : FRAC], clamping when the dropped top
    // bits disagree with the slice sign.
    function automatic sample_t sat_slice(acc_t a);
        logic [AW-1-(2*DW-2):0] top;
        top = a[AW-1:2*DW-2];
        if (top == '0 || top == '1)
            return a[2*DW-2:FRAC];
        else if (a[AW-1])
            return SAT_LO;
        else
            return SAT_HI;
    endfunction

endpackage

// File: rtl/iir_coef_bank.sv
module iir_coef_bank
    import iir_pkg::*;
#(
    parameter int      NWORDS  = 2,
    parameter sample_t A1_INIT = 24'sh733333,
    parameter sample_t B0_INIT = 24'sh0CCCCC,
    localparam int     SELW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [SELW-1:0] sel,
    input  sample_t         wdata,
    output coef_t           coefs
);

    sample_t word_q [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        localparam sample_t INIT = (g == 0) ? A1_INIT : B0_INIT;
        always_ff @(posedge clk) begin
            if (rst)
                word_q[g] <= INIT;
            else if (we && sel == SELW'(g))
                word_q[g] <= wdata;
        end
    end

    assign coefs.a1 = word_q[0];
    assign coefs.b0 = word_q[1];

endmodule

// File: rtl/iir_ctrl.sv
module iir_ctrl
    import iir_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    output logic   in_ready,
    output logic   accept,
    output phase_e phase,
    output logic   out_valid
);

    phase_e phase_d;

    assign in_ready = (phase == ST_IDLE);
    assign accept   = in_valid && in_ready;

    always_comb begin
        unique case (phase)
            ST_IDLE: phase_d = accept ? ST_FB : ST_IDLE;
            ST_FB:   phase_d = ST_IN;
            ST_IN:   phase_d = ST_SAT;
            default: phase_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_IDLE;
            out_valid <= 1'b0;
        end else begin
            phase     <= phase_d;
            out_valid <= (phase == ST_SAT);
        end
    end

    // R4: result strobe lasts exactly one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4: the filter is ready again when the strobe appears
    a_r4_ready_with_strobe: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

endmodule

// File: rtl/iir_mac.sv
module iir_mac
    import iir_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  phase_e  phase,
    input  sample_t fb_val,
    input  sample_t fb_coef,
    input  sample_t in_val,
    input  sample_t in_coef,
    output acc_t    acc
);

    sample_t op_a, op_b;
    acc_t    prod;

    // One shared multiplier: the feedback term first, then the input term.
    always_comb begin
        op_a = (phase == ST_FB) ? fb_val  : in_val;
        op_b = (phase == ST_FB) ? fb_coef : in_coef;
        prod = acc_t'(op_a) * acc_t'(op_b);
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else begin
            unique case (phase)
                ST_FB:   acc <= prod;
                ST_IN:   acc <= acc + prod;
                default: acc <= acc;
            endcase
        end
    end

    // R5: the accumulator does not move while the filter is idle
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IDLE) |=> $stable(acc));

endmodule

// File: rtl/iir_q23_lowpass.sv
module iir_q23_lowpass
    import iir_pkg::*;
#(
    parameter logic [23:0] A1_INIT = 24'h733333,
    parameter logic [23:0] B0_INIT = 24'h0CCCCC
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [23:0] in_data,
    input  logic        coef_we,
    input  logic        coef_sel,
    input  logic [23:0] coef_wdata,
    output logic        out_valid,
    output logic [23:0] out_data
);

    phase_e  phase;
    logic    accept;
    coef_t   cf_live, cf_snap;
    sample_t x_q, y_prev, out_q, y_next;
    acc_t    acc;

    iir_coef_bank #(
        .NWORDS (2),
        .A1_INIT(sample_t'(A1_INIT)),
        .B0_INIT(sample_t'(B0_INIT))
    ) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (coef_we),
        .sel  (coef_sel),
        .wdata(sample_t'(coef_wdata)),
        .coefs(cf_live)
    );

    iir_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .accept   (accept),
        .phase    (phase),
        .out_valid(out_valid)
    );

    iir_mac u_mac (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .fb_val (y_prev),
        .fb_coef(cf_snap.a1),
        .in_val (x_q),
        .in_coef(cf_snap.b0),
        .acc    (acc)
    );

    assign y_next = sat_slice(acc);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q     <= '0;
            cf_snap <= '0;
            y_prev  <= '0;
            out_q   <= '0;
        end else begin
            if (accept) begin
                x_q     <= sample_t'(in_data);
                cf_snap <= cf_live;
            end
            if (phase == ST_SAT) begin
                out_q  <= y_next;
                y_prev <= y_next;
            end
            if (clr)
                y_prev <= '0;
        end
    end

    assign out_data = out_q;

    // R3: an offer refused while busy leaves the captured sample alone
    a_r3_busy_offer_ignored: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> $stable(x_q));

    // R9: coefficients in use stay fixed for the whole computation
    a_r9_snapshot_stable: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_IDLE && phase != ST_FB) |-> $stable(cf_snap));

    // R8: clear zeroes the stored previous output
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |=> (y_prev == '0));

    // R6: saturation keeps the sign of the full-width sum
    a_r6_sign_kept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[23] == acc[AW-1]));

    // R7: the feedback register matches the shown result unless cleared
    a_r7_feedback_is_output: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(clr)) |-> (y_prev == out_q));

endmodule

// File: tb/tb_iir_q23_lowpass.sv
`timescale 1ns/1ps
module tb_iir_q23_lowpass;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_data = '0;
    logic        coef_we = 1'b0;
    logic        coef_sel = 1'b0;
    logic [23:0] coef_wdata = '0;
    logic        out_valid;
    logic [23:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench-side model state
    logic [23:0] m_a1, m_b0, m_y;

    always #5 clk = ~clk;

    iir_q23_lowpass dut (
        .clk(clk), .rst(rst), .clr(clr),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .coef_we(coef_we), .coef_sel(coef_sel), .coef_wdata(coef_wdata),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [23:0] model(input logic signed [23:0] y,
                                          input logic signed [23:0] a,
                                          input logic signed [23:0] x,
                                          input logic signed [23:0] b);
        longint s, r;
        s = longint'(y) * longint'(a) + longint'(x) * longint'(b);
        r = s >>> 23;
        if (r > 64'sd8388607)       return 24'h7FFFFF;
        else if (r < -64'sd8388608) return 24'h800000;
        else                        return r[23:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_coef(input logic sel, input logic [23:0] v);
        @(negedge clk);
        coef_we = 1'b1; coef_sel = sel; coef_wdata = v;
        @(negedge clk);
        coef_we = 1'b0;
        if (sel) m_b0 = v; else m_a1 = v;
    endtask

    // One sample through the filter, checking timing and value.
    task automatic do_sample(input logic [23:0] x, input string req,
                             input bit mid_write, input logic [23:0] new_b0,
                             input bit hold_valid);
        logic [23:0] exp;
        exp = model(m_y, m_a1, x, m_b0);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = x;
        @(negedge clk);                       // accepting edge passed
        if (hold_valid) in_data = ~x; else in_valid = 1'b0;
        if (mid_write) begin
            coef_we = 1'b1; coef_sel = 1'b1; coef_wdata = new_b0;
        end
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            coef_we = 1'b0;
            if (k == 2) in_valid = 1'b0;
            if (k == 3) begin
                chk(out_valid === 1'b1, "R4", "strobe on third edge",
                    {23'd0, out_valid}, 24'd1);
                chk(in_ready === 1'b1, "R4", "ready with strobe",
                    {23'd0, in_ready}, 24'd1);
                chk(out_data === exp, req, "result", out_data, exp);
            end else begin
                chk(out_valid === 1'b0, "R4", "no strobe off slot",
                    {23'd0, out_valid}, 24'd0);
            end
        end
        m_y = exp;
        if (mid_write) m_b0 = new_b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_a1 = 24'h733333; m_b0 = 24'h0CCCCC; m_y = '0;
    endtask

    initial begin
        logic [23:0] d;
        void'($urandom(32'd20161211));
        do_reset();
        @(negedge clk);
        chk(in_ready === 1'b1, "R1", "ready after reset", {23'd0, in_ready}, 24'd1);
        chk(out_valid === 1'b0, "R1", "no strobe after reset", {23'd0, out_valid}, 24'd0);
        chk(out_data === 24'd0, "R1", "output zero after reset", out_data, 24'd0);

        // R1/R2: first result uses zero history and default b0
        do_sample(24'h400000, "R2", 0, 0, 0);
        chk(m_y == 24'h066666, "R2", "default b0 product", m_y, 24'h066666);

        // R10: DC convergence with defaults
        for (int i = 0; i < 200; i++) do_sample(24'h400000, "R5", 0, 0, 0);
        d = (out_data > 24'h400000) ? out_data - 24'h400000 : 24'h400000 - out_data;
        chk(d < 24'd64, "R10", "settled near input", out_data, 24'h400000);

        // R8: clear zeroes history
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
        m_y = '0;
        do_sample(24'h100000, "R8", 0, 0, 0);

        // R5: random inputs with occasional idle coefficient writes
        for (int i = 0; i < 300; i++) begin
            if (($urandom % 16) == 0) write_coef(1'($urandom % 2), 24'($urandom));
            do_sample(24'($urandom), "R5", 0, 0, 0);
        end

        // R6: positive and negative clamps
        write_coef(1'b0, 24'h7FFFFF);
        write_coef(1'b1, 24'h7FFFFF);
        for (int i = 0; i < 4; i++) do_sample(24'h7FFFFF, "R6", 0, 0, 0);
        chk(out_data === 24'h7FFFFF, "R6", "upper rail", out_data, 24'h7FFFFF);
        for (int i = 0; i < 6; i++) do_sample(24'h800000, "R6", 0, 0, 0);
        chk(out_data === 24'h800000, "R6", "lower rail", out_data, 24'h800000);
        write_coef(1'b0, 24'h000000);
        write_coef(1'b1, 24'h800000);
        do_sample(24'h800000, "R6", 0, 0, 0);
        chk(out_data === 24'h7FFFFF, "R6", "-1 times -1 clamps", out_data, 24'h7FFFFF);

        // R7: the clamped value is what gets fed back
        write_coef(1'b0, 24'h400000);
        write_coef(1'b1, 24'h000000);
        do_sample(24'h123456, "R7", 0, 0, 0);
        chk(out_data === 24'h3FFFFF, "R7", "half of clamped feedback", out_data, 24'h3FFFFF);

        // R9: coefficient write during a computation
        write_coef(1'b0, 24'h733333);
        write_coef(1'b1, 24'h0CCCCC);
        do_sample(24'h200000, "R9", 1, 24'h200000, 0);
        do_sample(24'h200000, "R9", 0, 0, 0);

        // R3: held offer while busy is not taken
        do_sample(24'h300000, "R3", 0, 0, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R3", "no extra result", {23'd0, out_valid}, 24'd0);
        end
        do_sample(24'h050000, "R3", 0, 0, 0);

        // R8: reset also clears history
        do_reset();
        do_sample(24'h7FFFFF, "R8", 0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule